// File: doc/BRIEF.md
# Multi-Channel Stream Unpacker

This block takes a packed sample stream and spreads it over several output channels. Input arrives on a valid/ready/data stream port. Each input beat carries `NUM_CH` samples of `SAMPLE_W` bits. The samples belong only to the channels that are currently enabled, and they cycle through those channels in ascending index order. A runtime enable mask with one bit per channel selects which channels take part.

On the output side there is a single read strobe shared by every channel. When the strobe is sampled high, the block looks at how many samples it holds. If it holds at least one sample per enabled channel, it serves the request: one clock later it raises a valid flag and presents one sample on each enabled channel's data lane. If it holds too few, it raises an underflow flag instead and consumes nothing.

A buffer of two beats keeps leftover samples. Because of this, a request can take its samples from the tail of one beat and the head of the next. The mask must not change while data is buffered.

Top module: `stream_unpacker`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `rd_valid` and `rd_underflow` are low and `s_ready` is high, because the buffer is empty.
- R2: The buffer holds 2*NUM_CH samples. `s_ready` is high exactly when at least NUM_CH slots are free. A beat offered while `s_ready` is low is not taken, and it leaves the sample order unchanged.
- R3: When `rd_req` is sampled high and the buffer holds at least popcount(`chan_en`) samples, `rd_valid` is high in the next cycle and `rd_underflow` is low.
- R4: When `rd_req` is sampled high and the buffer holds fewer than popcount(`chan_en`) samples, `rd_underflow` is high in the next cycle and `rd_valid` is low. No sample is consumed.
- R5: `rd_valid` and `rd_underflow` are never high together. Both are low in any cycle that was not preceded by a sampled `rd_req`.
- R6: In a valid cycle, enabled channel c shows on `rd_data[c*SAMPLE_W +: SAMPLE_W]` the buffered sample whose position from the oldest equals the number of enabled channels below c.
- R7: Each served request removes exactly popcount(`chan_en`) samples from the front of the buffer, in arrival order. A request may therefore span two input beats.
- R8: With `chan_en` all zero, every request returns valid and consumes nothing.
- R9: Within an accepted beat, lane i is `s_data[i*SAMPLE_W +: SAMPLE_W]`, and lane 0 is the oldest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | NUM_CH | Per-channel enable mask |
| s_valid | input | 1 | Input beat offered |
| s_ready | output | 1 | Buffer has room for a full beat |
| s_data | input | NUM_CH*SAMPLE_W | Packed input beat, lane 0 oldest |
| rd_req | input | 1 | Shared read request |
| rd_valid | output | 1 | Previous request served |
| rd_underflow | output | 1 | Previous request could not be served |
| rd_data | output | NUM_CH*SAMPLE_W | Per-channel samples, valid with `rd_valid` |

## Verification
The outcome of a request sampled at one rising edge (`rd_valid` or `rd_underflow`, together with the channel data) is registered at that same edge. It is therefore due exactly one cycle after the request. `s_ready` depends only on the fill level, so it is due in the same cycle as the edge that changed that level. The driver applies inputs at the falling edge and tags each expected item with the cycle number in which it is due. The monitor compares an item only at the falling edge of that cycle. The bench's model queue of samples is updated in the same order as the hardware: the pop for a request is judged against the level before the edge, and the beat accepted at that edge is appended afterwards.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

  // number of set bits in a mask of up to 64 channels
  function automatic int count_ones(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/unpk_sample_buf.sv
// Sample FIFO with parallel front window: pops a variable number of samples
// from the front and appends one whole beat behind what remains.
module unpk_sample_buf #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16,
  localparam int SLOTS   = 2 * NUM_CH,
  localparam int CW      = $clog2(SLOTS + 1),
  localparam int BW      = NUM_CH * SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [BW-1:0] push_data,
  input  logic          pop,
  input  logic [CW-1:0] pop_cnt,
  output logic [BW-1:0] head,
  output logic [CW-1:0] level,
  output logic          room
);

  logic [SAMPLE_W-1:0] slot_q [SLOTS];
  logic [SAMPLE_W-1:0] slot_d [SLOTS];
  logic [CW-1:0]       count_q, count_d;

  always_comb begin
    int popn;
    int keep;
    popn = pop ? int'(pop_cnt) : 0;
    keep = int'(count_q) - popn;
    for (int i = 0; i < SLOTS; i++) begin
      slot_d[i] = slot_q[i];
      if (i < keep)
        slot_d[i] = slot_q[i + popn];
      else if (push && (i - keep) < NUM_CH)
        slot_d[i] = push_data[(i - keep) * SAMPLE_W +: SAMPLE_W];
    end
    count_d = CW'(keep + (push ? NUM_CH : 0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
    for (int i = 0; i < SLOTS; i++) slot_q[i] <= slot_d[i];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_head
      assign head[g*SAMPLE_W +: SAMPLE_W] = slot_q[g];
    end
  endgenerate

  assign level = count_q;
  assign room  = (int'(count_q) <= SLOTS - NUM_CH);

  // R7: a pop never removes more than is held
  a_r7_pop_le_level: assert property (@(posedge clk) disable iff (rst)
    pop |-> (pop_cnt <= count_q));
  // R2: a push is only taken with room for a full beat
  a_r2_push_has_room: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(count_q) <= SLOTS - NUM_CH));
  // R2: fill level never exceeds capacity
  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    int'(count_q) <= SLOTS);
  // R4: without push or pop the level holds
  a_r4_level_hold: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(count_q));

endmodule

// File: rtl/unpk_lane_route.sv
// Maps the buffer front window to channels: channel c takes the sample at the
// position equal to the count of enabled channels below c.
module unpk_lane_route
  import unpk_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16,
  localparam int BW      = NUM_CH * SAMPLE_W
) (
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [BW-1:0]     head,
  output logic [BW-1:0]     routed
);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      int rank;
      always_comb begin
        rank = count_ones(64'(chan_en) & ((64'd1 << c) - 64'd1));
        routed[c*SAMPLE_W +: SAMPLE_W] = head[rank*SAMPLE_W +: SAMPLE_W];
      end
    end
  endgenerate

endmodule

// File: rtl/unpk_ctrl.sv
// Request decision and registered response flags.
module unpk_ctrl
  import unpk_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SLOTS = 2 * NUM_CH,
  localparam int CW    = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [CW-1:0]     level,
  output logic              pop,
  output logic [CW-1:0]     pop_cnt,
  output logic              valid_q,
  output logic              uflow_q
);

  int need;
  logic enough;

  always_comb begin
    need    = count_ones(64'(chan_en));
    enough  = int'(level) >= need;
    pop     = rd_req && enough;
    pop_cnt = CW'(need);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      valid_q <= rd_req && enough;
      uflow_q <= rd_req && !enough;
    end
  end

  // R5: flags are exclusive
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(valid_q && uflow_q));
  // R5: a flag implies a request one cycle earlier
  a_r5_needs_req: assert property (@(posedge clk) disable iff (rst)
    (valid_q || uflow_q) |-> $past(rd_req));
  // R4: too few samples gives underflow next cycle
  a_r4_short_uflow: assert property (@(posedge clk) disable iff (rst)
    (rd_req && int'(level) < count_ones(64'(chan_en))) |=> uflow_q);
  // R8: empty mask is always served
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (rd_req && chan_en == '0) |=> valid_q);

endmodule

// File: rtl/stream_unpacker.sv
module stream_unpacker #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16,
  localparam int SLOTS   = 2 * NUM_CH,
  localparam int CW      = $clog2(SLOTS + 1),
  localparam int BW      = NUM_CH * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BW-1:0]     s_data,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic              rd_underflow,
  output logic [BW-1:0]     rd_data
);

  logic [BW-1:0] head, routed;
  logic [CW-1:0] level, pop_cnt;
  logic          room, pop, push;
  logic [BW-1:0] data_q;

  assign push    = s_valid && room;
  assign s_ready = room;

  unpk_sample_buf #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_buf (
    .clk(clk), .rst(rst), .push(push), .push_data(s_data),
    .pop(pop), .pop_cnt(pop_cnt), .head(head), .level(level), .room(room)
  );

  unpk_lane_route #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_route (
    .chan_en(chan_en), .head(head), .routed(routed)
  );

  unpk_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .rd_req(rd_req), .chan_en(chan_en), .level(level),
    .pop(pop), .pop_cnt(pop_cnt), .valid_q(rd_valid), .uflow_q(rd_underflow)
  );

  always_ff @(posedge clk) begin
    if (pop) data_q <= routed;
  end
  assign rd_data = data_q;

  // R3: a served pop shows valid on the next cycle
  a_r3_pop_to_valid: assert property (@(posedge clk) disable iff (rst)
    pop |=> (rd_valid && !rd_underflow));
  // R2: ready is low whenever fewer than a beat of slots are free
  a_r2_ready_level: assert property (@(posedge clk) disable iff (rst)
    (int'(level) > SLOTS - NUM_CH) |-> !s_ready);

endmodule

// File: tb/stream_unpacker_bench.sv
`timescale 1ns/1ps
module stream_unpacker_bench;
  localparam int NCH = 4;
  localparam int SW  = 16;
  localparam int BW  = NCH * SW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst = 1'b1;
  logic [NCH-1:0] chan_en = '0;
  logic           s_valid = 1'b0;
  logic           s_ready;
  logic [BW-1:0]  s_data = '0;
  logic           rd_req = 1'b0;
  logic           rd_valid, rd_underflow;
  logic [BW-1:0]  rd_data;

  stream_unpacker #(.NUM_CH(NCH), .SAMPLE_W(SW)) u_stream_unpacker (
    .clk(clk), .rst(rst), .chan_en(chan_en), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_underflow(rd_underflow), .rd_data(rd_data)
  );

  typedef struct {
    int             due;
    bit             rd;
    bit             ok;
    logic [NCH-1:0] en;
    logic [BW-1:0]  data;
  } exp_t;

  exp_t sb[$];
  int   mdl[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   seq = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int ones(input logic [NCH-1:0] m);
    int n = 0;
    for (int i = 0; i < NCH; i++) n += int'(m[i]);
    return n;
  endfunction

  // monitor: compares each expected item in the cycle it is due
  always @(negedge clk) begin
    if (!rst && sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (!e.rd) begin
        chk(!rd_valid && !rd_underflow, "R5", "idle flags",
            {rd_valid, rd_underflow}, 0);
      end else if (e.ok) begin
        chk(rd_valid && !rd_underflow, e.en == '0 ? "R8" : "R3", "served flags",
            {rd_valid, rd_underflow}, 2);
        for (int c = 0; c < NCH; c++)
          if (e.en[c])
            chk(rd_data[c*SW +: SW] == e.data[c*SW +: SW], "R6", "channel data",
                rd_data[c*SW +: SW], e.data[c*SW +: SW]);
      end else begin
        chk(rd_underflow && !rd_valid, "R4", "underflow flags",
            {rd_valid, rd_underflow}, 1);
      end
    end
  end

  // driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic step(input bit rd, input bit v);
    exp_t e;
    int   k;
    int   r;
    @(negedge clk);
    rd_req  = rd;
    s_valid = v;
    for (int j = 0; j < NCH; j++) s_data[j*SW +: SW] = SW'(seq + j);  // R9 lane order
    chk(s_ready == (mdl.size() <= NCH), "R2", "ready vs level", s_ready, mdl.size() <= NCH);
    k      = ones(chan_en);
    e.due  = cyc + 1;
    e.rd   = rd;
    e.en   = chan_en;
    e.ok   = 1'b0;
    e.data = '0;
    if (rd && mdl.size() >= k) begin
      e.ok = 1'b1;
      r = 0;
      for (int c = 0; c < NCH; c++)
        if (chan_en[c]) begin
          e.data[c*SW +: SW] = SW'(mdl.pop_front());  // R7 front removal
          r++;
        end
    end
    sb.push_back(e);
    if (v && s_ready) begin
      for (int j = 0; j < NCH; j++) mdl.push_back(seq + j);
      seq += NCH;
    end
  endtask

  task automatic do_reset(input logic [NCH-1:0] m);
    @(negedge clk);
    rst = 1'b1; rd_req = 1'b0; s_valid = 1'b0; chan_en = m;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    sb.delete();
    mdl.delete();
    chk(!rd_valid && !rd_underflow && s_ready, "R1", "state after reset",
        {rd_valid, rd_underflow, s_ready}, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    // R3 R6: full mask, one beat, one read
    do_reset(4'b1111);
    step(1'b1, 1'b0);               // R4: empty buffer underflows
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);               // R5 idle
    // R7: three channels, request spans two beats
    do_reset(4'b1011);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);               // 1 left, needs 3 -> underflow
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);               // spans beats
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    // R2: fill until ready drops, offered beat held off, then drain in order
    do_reset(4'b0101);
    repeat (4) step(1'b0, 1'b1);
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    // R8: empty mask
    do_reset(4'b0000);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    // every mask with mixed traffic, simultaneous push and pop included
    for (int m = 0; m < (1 << NCH); m++) begin
      do_reset(NCH'(m));
      for (int t = 0; t < 40; t++)
        step(bit'($urandom % 2), bit'(($urandom % 3) != 0));
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule